// File: doc/BRIEF.md
# Power Button Conditioner

This block takes the raw active-low signal from a front-panel power button and turns it into clean, single-cycle event pulses for the power-management logic. The raw level is first brought into the clock domain through a flop chain. It is then filtered, so that a change of level counts only once it has held for a programmable number of ticks of a slow timebase. Contact bounce and short glitches are removed this way.

A press that passes the filter is classified by the state of the system at that moment. If the system is asleep, the press raises a wake event immediately. If the system is working, a sleep-request event (to be routed to an SMI or SCI) is raised when the button is released. A press held for a second, longer programmable interval raises an unconditional request to go to soft-off (S5), whatever the sleep state. That request fires once per press, and it cancels the sleep request the release would otherwise raise. With a 1 ms tick, the default parameters give a 16 ms filter and a 4 s hold.

Top module: `pwrbtn_cond`

## Requirements
- R1: After reset every event output is low and the button is treated as released; `btn_n_i` is active low (0 means pressed) and passes through `SYNC_STAGES` flops before filtering.
- R2: A filtered level changes only on the `DEB_TICKS`-th tick during which the synchronized input has differed from it without interruption; a press or release lasting fewer ticks produces no event.
- R3: A press accepted while `sleeping_i` is 1 produces exactly one `wake_o` pulse, in the clock cycle after the accepting tick, i.e. `DEB_TICKS` ticks after the input fell.
- R4: A press accepted while `sleeping_i` is 0 produces exactly one `sleep_req_o` pulse, `DEB_TICKS` ticks after the input rose again; the sleep state is sampled at acceptance, and later changes of `sleeping_i` do not alter the outcome.
- R5: When the filtered press has lasted `HOLD_TICKS` ticks after its acceptance, exactly one `override_o` pulse is raised; it never repeats within the same press.
- R6: The release of a press that raised `override_o` produces no `sleep_req_o`; the release of a press that raised `wake_o` produces no `sleep_req_o` either.
- R7: Every event output is high for one clock cycle only, and at most one of the three is high in any cycle.
- R8: The override is raised in the same way whether the press began asleep or working.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Block clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tick_i | input | 1 | One-cycle pulse of the slow timebase |
| btn_n_i | input | 1 | Raw button level, 0 = pressed, asynchronous |
| sleeping_i | input | 1 | 1 while the system is in a sleep state |
| wake_o | output | 1 | Wake event pulse |
| sleep_req_o | output | 1 | Sleep-request interrupt event pulse |
| override_o | output | 1 | Unconditional soft-off request pulse |

## Verification
A hold or filter counter that is off by one moves the tick at which an event pulse appears. The bench therefore timestamps every pulse in ticks of its own timebase and compares it against the exact tick where it is due, and any shift shows up within one tick period. A wrong press classification or a lost override flag shows up at the next release, as a missing, extra or wrong pulse. The sweep runs every hold length around the filter and hold limits in both sleep states, so a boundary error appears on the first length it affects.

// File: rtl/pwrbtn_pkg.sv
package pwrbtn_pkg;

   typedef enum logic [1:0] {
      BTN_IDLE     = 2'd0,
      BTN_HELD     = 2'd1,
      BTN_OVERRODE = 2'd2
   } btn_state_e;

   typedef struct packed {
      logic wake;
      logic sleep_req;
      logic override;
   } btn_events_t;

endpackage

// File: rtl/pwrbtn_sync.sv
module pwrbtn_sync #(
   parameter int unsigned STAGES  = 2,
   parameter bit          RST_VAL = 1'b1
) (
   input  logic clk_i,
   input  logic rst_ni,
   input  logic d_i,
   output logic q_o
);

   if (STAGES == 1) begin : g_bad_stages
      $error("pwrbtn_sync: STAGES must be 0 (bypass) or at least 2");
   end

   if (STAGES == 0) begin : g_bypass
      assign q_o = d_i;
   end else begin : g_chain
      for (genvar i = 0; i < STAGES; i++) begin : g_stage
         logic src;
         logic q;
         if (i == 0) begin : g_head
            assign src = d_i;
         end else begin : g_tail
            assign src = g_stage[i-1].q;
         end
         always_ff @(posedge clk_i or negedge rst_ni) begin
            if (!rst_ni) q <= RST_VAL;
            else         q <= src;
         end
      end
      assign q_o = g_stage[STAGES-1].q;
   end

endmodule

// File: rtl/pwrbtn_debounce.sv
module pwrbtn_debounce #(
   parameter int unsigned TICKS = 16
) (
   input  logic clk_i,
   input  logic rst_ni,
   input  logic tick_i,
   input  logic level_i,
   output logic level_o
);

   localparam int unsigned CW = (TICKS < 2) ? 1 : $clog2(TICKS);
   localparam logic [CW-1:0] LAST = CW'(TICKS - 1);

   if (TICKS < 1) begin : g_bad_ticks
      $error("pwrbtn_debounce: TICKS must be at least 1");
   end

   logic [CW-1:0] run_q;
   logic          level_q;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         run_q   <= '0;
         level_q <= 1'b0;
      end else if (level_i == level_q) begin
         run_q <= '0;
      end else if (tick_i) begin
         if (run_q == LAST) begin
            level_q <= level_i;
            run_q   <= '0;
         end else begin
            run_q <= run_q + 1'b1;
         end
      end
   end

   assign level_o = level_q;

endmodule

// File: rtl/pwrbtn_event_fsm.sv
module pwrbtn_event_fsm
   import pwrbtn_pkg::*;
#(
   parameter int unsigned HOLD_TICKS = 4000
) (
   input  logic        clk_i,
   input  logic        rst_ni,
   input  logic        tick_i,
   input  logic        pressed_i,
   input  logic        sleeping_i,
   output btn_events_t events_o
);

   localparam int unsigned HW = $clog2(HOLD_TICKS);
   localparam logic [HW-1:0] HOLD_LAST = HW'(HOLD_TICKS - 1);

   if (HOLD_TICKS < 2) begin : g_bad_hold
      $error("pwrbtn_event_fsm: HOLD_TICKS must be at least 2");
   end

   btn_state_e  state_q;
   logic [HW-1:0] hold_q;
   logic        began_asleep_q;
   btn_events_t ev_q;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         state_q        <= BTN_IDLE;
         hold_q         <= '0;
         began_asleep_q <= 1'b0;
         ev_q           <= '0;
      end else begin
         ev_q <= '0;
         unique case (state_q)
            BTN_IDLE: begin
               if (pressed_i) begin
                  state_q        <= BTN_HELD;
                  hold_q         <= '0;
                  began_asleep_q <= sleeping_i;
                  ev_q.wake      <= sleeping_i;
               end
            end
            BTN_HELD: begin
               if (!pressed_i) begin
                  state_q        <= BTN_IDLE;
                  ev_q.sleep_req <= !began_asleep_q;
               end else if (tick_i) begin
                  if (hold_q == HOLD_LAST) begin
                     state_q       <= BTN_OVERRODE;
                     ev_q.override <= 1'b1;
                  end else begin
                     hold_q <= hold_q + 1'b1;
                  end
               end
            end
            BTN_OVERRODE: begin
               if (!pressed_i) state_q <= BTN_IDLE;
            end
            default: state_q <= BTN_IDLE;
         endcase
      end
   end

   assign events_o = ev_q;

endmodule

// File: rtl/pwrbtn_cond.sv
module pwrbtn_cond
   import pwrbtn_pkg::*;
#(
   parameter int unsigned SYNC_STAGES = 2,
   parameter int unsigned DEB_TICKS   = 16,
   parameter int unsigned HOLD_TICKS  = 4000
) (
   input  logic clk_i,
   input  logic rst_ni,
   input  logic tick_i,
   input  logic btn_n_i,
   input  logic sleeping_i,
   output logic wake_o,
   output logic sleep_req_o,
   output logic override_o
);

   logic        btn_n_sync;
   logic        deb_pressed;
   btn_events_t events;

   pwrbtn_sync #(
      .STAGES  (SYNC_STAGES),
      .RST_VAL (1'b1)
   ) u_sync (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .d_i    (btn_n_i),
      .q_o    (btn_n_sync)
   );

   pwrbtn_debounce #(
      .TICKS (DEB_TICKS)
   ) u_deb (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .tick_i  (tick_i),
      .level_i (!btn_n_sync),
      .level_o (deb_pressed)
   );

   pwrbtn_event_fsm #(
      .HOLD_TICKS (HOLD_TICKS)
   ) u_fsm (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .tick_i     (tick_i),
      .pressed_i  (deb_pressed),
      .sleeping_i (sleeping_i),
      .events_o   (events)
   );

   assign wake_o      = events.wake;
   assign sleep_req_o = events.sleep_req;
   assign override_o  = events.override;

endmodule

// File: rtl/pwrbtn_cond_chk.sv
module pwrbtn_cond_chk (
   input logic clk_i,
   input logic rst_ni,
   input logic tick_i,
   input logic sleeping_i,
   input logic deb_pressed,
   input logic wake_o,
   input logic sleep_req_o,
   input logic override_o
);

   logic deb_prev_q;
   logic ovr_latch_q;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         deb_prev_q  <= 1'b0;
         ovr_latch_q <= 1'b0;
      end else begin
         deb_prev_q <= deb_pressed;
         if (override_o)                      ovr_latch_q <= 1'b1;
         else if (deb_pressed && !deb_prev_q) ovr_latch_q <= 1'b0;
      end
   end

   AST_DEB_ON_TICK: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !$stable(deb_pressed) |-> $past(tick_i)); // R2

   AST_WAKE_AT_PRESS: assert property (@(posedge clk_i) disable iff (!rst_ni)
      wake_o |-> ($past(deb_pressed) && $past(sleeping_i))); // R3

   AST_SLEEP_AT_RELEASE: assert property (@(posedge clk_i) disable iff (!rst_ni)
      sleep_req_o |-> !$past(deb_pressed)); // R4

   AST_OVR_ON_TICK: assert property (@(posedge clk_i) disable iff (!rst_ni)
      override_o |-> ($past(tick_i) && $past(deb_pressed))); // R5

   AST_OVR_ONCE: assert property (@(posedge clk_i) disable iff (!rst_ni)
      override_o |-> !ovr_latch_q); // R5

   AST_NO_SLEEP_AFTER_OVR: assert property (@(posedge clk_i) disable iff (!rst_ni)
      sleep_req_o |-> !ovr_latch_q); // R6

   AST_EVENTS_EXCLUSIVE: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $onehot0({wake_o, sleep_req_o, override_o})); // R7

   AST_WAKE_ONE_CYCLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
      wake_o |=> !wake_o); // R7

   AST_SLEEP_ONE_CYCLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
      sleep_req_o |=> !sleep_req_o); // R7

   AST_OVR_ONE_CYCLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
      override_o |=> !override_o); // R7

endmodule

bind pwrbtn_cond pwrbtn_cond_chk u_chk (
   .clk_i       (clk_i),
   .rst_ni      (rst_ni),
   .tick_i      (tick_i),
   .sleeping_i  (sleeping_i),
   .deb_pressed (deb_pressed),
   .wake_o      (wake_o),
   .sleep_req_o (sleep_req_o),
   .override_o  (override_o)
);

// File: tb/pwrbtn_cond_bench.sv
`timescale 1ns/1ps
module pwrbtn_cond_bench;

   localparam int DEB  = 3;
   localparam int HOLD = 6;
   localparam int TPER = 5;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic tick = 1'b0;
   logic btn_n = 1'b1;
   logic sleeping = 1'b0;
   logic wake, sleep_req, override;

   int checks = 0;
   int failures = 0;
   bit done = 1'b0;
   int cyc = 0;
   int tcnt = 0;

   int n_wake, n_slp, n_ovr;
   int at_wake, at_slp, at_ovr;

   always #5 clk = ~clk;

   pwrbtn_cond #(
      .SYNC_STAGES (2),
      .DEB_TICKS   (DEB),
      .HOLD_TICKS  (HOLD)
   ) u_pwrbtn_cond (
      .clk_i       (clk),
      .rst_ni      (rst_n),
      .tick_i      (tick),
      .btn_n_i     (btn_n),
      .sleeping_i  (sleeping),
      .wake_o      (wake),
      .sleep_req_o (sleep_req),
      .override_o  (override)
   );

   always @(negedge clk) begin
      cyc  <= cyc + 1;
      tick <= ((cyc % TPER) == 0) && rst_n;
   end

   always @(posedge clk) if (tick) tcnt <= tcnt + 1;

   always @(negedge clk) begin
      if (rst_n) begin
         if (wake)      begin n_wake++; at_wake = tcnt; end
         if (sleep_req) begin n_slp++;  at_slp  = tcnt; end
         if (override)  begin n_ovr++;  at_ovr  = tcnt; end
      end
   end

   task automatic check(input bit ok, input string req, input string what,
                        input int act, input int exp);
      checks++;
      if (!ok) begin
         failures++;
         $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
      end
   endtask

   task automatic after_tick();
      @(posedge clk iff tick);
      @(negedge clk);
   endtask

   // press for len ticks; optionally flip the sleep state during the hold
   task automatic run_press(input int len, input bit slp, input bit flip_mid);
      int t_press, t_rel;
      bit accepted, exp_ovr, exp_slp;
      sleeping = slp;
      after_tick();
      n_wake = 0; n_slp = 0; n_ovr = 0;
      btn_n = 1'b0;
      t_press = tcnt;
      for (int k = 0; k < len; k++) begin
         after_tick();
         if (flip_mid && k == DEB + 1) sleeping = !slp;
      end
      btn_n = 1'b1;
      t_rel = tcnt;
      for (int k = 0; k < DEB + 3; k++) after_tick();
      accepted = (len >= DEB);
      exp_ovr  = accepted && (len >= HOLD);
      exp_slp  = accepted && !slp && !exp_ovr;
      if (!accepted) begin
         check(n_wake + n_slp + n_ovr == 0, "R2", "short press events",
               n_wake + n_slp + n_ovr, 0);
      end else begin
         check(n_wake == int'(slp), "R3", "wake count", n_wake, int'(slp));
         if (slp && n_wake == 1)
            check(at_wake - t_press == DEB, "R3", "wake tick", at_wake - t_press, DEB);
         check(n_slp == int'(exp_slp), exp_ovr ? "R6" : "R4", "sleep count",
               n_slp, int'(exp_slp));
         if (exp_slp && n_slp == 1)
            check(at_slp - t_rel == DEB, "R4", "sleep tick", at_slp - t_rel, DEB);
         check(n_ovr == int'(exp_ovr), slp ? "R8" : "R5", "override count",
               n_ovr, int'(exp_ovr));
         if (exp_ovr && n_ovr == 1)
            check(at_ovr - t_press == DEB + HOLD, "R5", "override tick",
                  at_ovr - t_press, DEB + HOLD);
      end
   endtask

   initial begin
      repeat (3) @(negedge clk);
      check({wake, sleep_req, override} == 3'b000, "R1", "outputs in reset",
            int'({wake, sleep_req, override}), 0);
      rst_n = 1'b1;
      repeat (4 * TPER) @(negedge clk);
      check({wake, sleep_req, override} == 3'b000, "R1", "idle after reset",
            int'({wake, sleep_req, override}), 0);
      // sub-tick glitch: low for one cycle only
      n_wake = 0; n_slp = 0; n_ovr = 0;
      after_tick();
      @(negedge clk) btn_n = 1'b0;
      @(negedge clk) btn_n = 1'b1;
      for (int k = 0; k < DEB + 2; k++) after_tick();
      check(n_wake + n_slp + n_ovr == 0, "R2", "one-cycle glitch",
            n_wake + n_slp + n_ovr, 0);
      for (int s = 0; s < 2; s++)
         for (int len = 1; len <= HOLD + 3; len++)
            run_press(len, bit'(s), 1'b0);
      // sleep state sampled at acceptance, later changes ignored
      run_press(DEB + 3, 1'b0, 1'b1);
      run_press(DEB + 3, 1'b1, 1'b1);
      run_press(HOLD + 2, 1'b1, 1'b1);
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         failures++;
         checks++;
         $display("FAIL R1 watchdog: actual=%0d expected=%0d", 0, 1);
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

endmodule